// File: doc/BRIEF.md
# Layer-2 Tunnel Frame Packer

This block gathers small memory-transaction packets (writes that carry data, and read requests that carry only a header) and packs one or more of them into the body of a single VLAN-tagged layer-2 Ethernet frame. Each frame body opens with both MAC addresses, a VLAN tag that carries a two-bit priority, a configurable EtherType and a three-byte tunnel header with its own CRC. The grouped packets follow, each closed by a CRC of its own. Preamble, start delimiter, frame check sequence, MAC and PHY sit outside the block. The frame bytes go to a downstream framer.

Packets arrive one byte per transfer on a valid/ready stream. The packet length and kind are held stable on `in_len` and `in_wr` for as long as the packet is being offered. Output is a byte stream with start-of-frame and end-of-frame flags and a ready signal for backpressure. Payload bytes are forwarded cut-through. Grouping stops when the next packet would exceed a configured payload budget, or when no further packet is waiting at the moment the decision is taken.

Top module: `l2_tunnel_packer`

## Requirements
- R1: After reset `out_valid` and `in_ready` are low, and they stay low until a packet is offered. The first frame after reset carries sequence number 0.
- R2: Each frame starts with 18 bytes in this order: destination MAC (6 bytes, most significant first), source MAC (6 bytes), 0x81, 0x00, the tag control byte {priority[1:0], 2'b00, vlan_id[11:8]}, vlan_id[7:0], then the EtherType (parameter, default 0x88B5) high byte first.
- R3: Bytes 18 to 20 hold the 24-bit tunnel header {flow_ctl[3:0], priority[1:0], payload_type[3:0], version[1:0], seq[11:0]}, most significant byte first. Bytes 21 and 22 hold the CRC of those three bytes, high byte first.
- R4: Every CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF, processed MSB first, with no reflection and no final XOR. Each grouped packet is followed by the CRC of its own bytes, high byte first.
- R5: A write packet forwards exactly `in_len` bytes. A read packet (`in_wr`=0) forwards exactly 8 header bytes, whatever value `in_len` has.
- R6: Each packet uses its length plus 2 bytes of the payload budget. A further packet joins the current frame only if the running total plus its cost is no more than `cfg_max_pld`.
- R7: The first packet of a frame is always taken, even when it alone exceeds `cfg_max_pld`.
- R8: If `in_valid` is low when the first CRC byte of a packet is accepted, the frame ends after that CRC.
- R9: `out_sof` marks the first byte of a frame and `out_eof` marks the last CRC byte. At least one cycle without `out_valid` follows every end of frame.
- R10: The sequence number goes up by one for every frame sent and wraps from 4095 to 0.
- R11: While `out_ready` is low, `out_valid` stays high and data and flags hold steady. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dst_mac | input | 48 | Destination MAC address |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_vid | input | 12 | VLAN identifier |
| cfg_pri | input | 2 | Priority, 0 lowest to 3 highest |
| cfg_fc | input | 4 | Flow-control bits for the tunnel header |
| cfg_ptype | input | 4 | Payload-type field |
| cfg_ver | input | 2 | Version field |
| cfg_max_pld | input | PLD_W | Payload budget in bytes after the header CRC |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input packet byte |
| in_len | input | LEN_W | Write packet length in bytes, held for the whole packet |
| in_wr | input | 1 | 1 for a write packet, 0 for a read request |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can accept a byte |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |

## Verification
A wrong byte counter or CRC register shows up at the ports no later than the end of the packet it affects. It appears as a shifted field in the first 23 bytes of a frame, or as a trailing CRC that does not match the bytes just forwarded. A wrong grouping decision shows at the next end of frame: the frame count for a packet list changes, and so do the `out_sof` and `out_eof` positions. A sequence register that fails to advance is seen in the header of the very next frame. The bench rebuilds every expected frame from the packet list and compares every byte and both flags.

// File: rtl/l2_tunnel_packer.sv
module l2_tunnel_packer #(
  parameter logic [15:0] ETYPE    = 16'h88B5,
  parameter int          LEN_W    = 8,
  parameter int          PLD_W    = 11,
  parameter int          RD_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      cfg_dst_mac,
  input  logic [47:0]      cfg_src_mac,
  input  logic [11:0]      cfg_vid,
  input  logic [1:0]       cfg_pri,
  input  logic [3:0]       cfg_fc,
  input  logic [3:0]       cfg_ptype,
  input  logic [1:0]       cfg_ver,
  input  logic [PLD_W-1:0] cfg_max_pld,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_wr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof
);
  localparam int CW = ((PLD_W > LEN_W) ? PLD_W : LEN_W) + 2;
  localparam logic [4:0] HDR_END = 5'd22;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PKT, S_CRC} st_t;

  st_t              st;
  logic [4:0]       hcnt;
  logic [LEN_W-1:0] bcnt;
  logic             cidx;
  logic             more;
  logic [15:0]      crc;
  logic [11:0]      seq;
  logic [PLD_W-1:0] used;
  logic [7:0]       hdr_byte;
  logic [LEN_W-1:0] cur_len;
  logic [CW-1:0]    need;
  logic             fire;
  logic [23:0]      thdr;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  assign thdr    = {cfg_fc, cfg_pri, cfg_ptype, cfg_ver, seq};
  assign cur_len = in_wr ? in_len : LEN_W'(RD_BYTES);
  assign need    = CW'(used) + CW'(cur_len) + CW'(4);

  always_comb begin
    case (hcnt)
      5'd0:    hdr_byte = cfg_dst_mac[47:40];
      5'd1:    hdr_byte = cfg_dst_mac[39:32];
      5'd2:    hdr_byte = cfg_dst_mac[31:24];
      5'd3:    hdr_byte = cfg_dst_mac[23:16];
      5'd4:    hdr_byte = cfg_dst_mac[15:8];
      5'd5:    hdr_byte = cfg_dst_mac[7:0];
      5'd6:    hdr_byte = cfg_src_mac[47:40];
      5'd7:    hdr_byte = cfg_src_mac[39:32];
      5'd8:    hdr_byte = cfg_src_mac[31:24];
      5'd9:    hdr_byte = cfg_src_mac[23:16];
      5'd10:   hdr_byte = cfg_src_mac[15:8];
      5'd11:   hdr_byte = cfg_src_mac[7:0];
      5'd12:   hdr_byte = 8'h81;
      5'd13:   hdr_byte = 8'h00;
      5'd14:   hdr_byte = {cfg_pri, 2'b00, cfg_vid[11:8]};
      5'd15:   hdr_byte = cfg_vid[7:0];
      5'd16:   hdr_byte = ETYPE[15:8];
      5'd17:   hdr_byte = ETYPE[7:0];
      5'd18:   hdr_byte = thdr[23:16];
      5'd19:   hdr_byte = thdr[15:8];
      5'd20:   hdr_byte = thdr[7:0];
      5'd21:   hdr_byte = crc[15:8];
      5'd22:   hdr_byte = crc[7:0];
      default: hdr_byte = 8'h00;
    endcase
  end

  assign out_valid = (st == S_HDR) || (st == S_CRC) || (st == S_PKT && in_valid);
  assign out_data  = (st == S_PKT) ? in_data :
                     (st == S_CRC) ? (cidx ? crc[7:0] : crc[15:8]) : hdr_byte;
  assign out_sof   = (st == S_HDR) && (hcnt == 5'd0);
  assign out_eof   = (st == S_CRC) && cidx && !more;
  assign in_ready  = (st == S_PKT) && out_ready;
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hcnt <= '0;
      bcnt <= '0;
      cidx <= 1'b0;
      more <= 1'b0;
      crc  <= 16'hFFFF;
      seq  <= '0;
      used <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          st   <= S_HDR;
          hcnt <= '0;
          crc  <= 16'hFFFF;
        end
        S_HDR: if (fire) begin
          if (hcnt >= 5'd18 && hcnt <= 5'd20) crc <= crc_step(crc, hdr_byte);
          if (hcnt == HDR_END) begin
            st   <= S_PKT;
            crc  <= 16'hFFFF;
            bcnt <= '0;
            used <= '0;
          end else begin
            hcnt <= hcnt + 5'd1;
          end
        end
        S_PKT: if (fire) begin
          crc  <= crc_step(crc, in_data);
          used <= used + PLD_W'(1);
          if (bcnt == cur_len - LEN_W'(1)) begin
            st   <= S_CRC;
            cidx <= 1'b0;
          end else begin
            bcnt <= bcnt + LEN_W'(1);
          end
        end
        S_CRC: if (fire) begin
          used <= used + PLD_W'(1);
          if (!cidx) begin
            cidx <= 1'b1;
            more <= in_valid && (need <= CW'(cfg_max_pld));
          end else if (more) begin
            st   <= S_PKT;
            crc  <= 16'hFFFF;
            bcnt <= '0;
          end else begin
            st  <= S_IDLE;
            seq <= seq + 12'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l2_tunnel_packer_chk.sv
module l2_tunnel_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_sof,
  input logic        out_eof,
  input logic [47:0] cfg_dst_mac,
  input logic [11:0] seq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && !in_ready);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

  // R9
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> !out_valid);

  // R10
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> seq == $past(seq) + 12'd1);

  // R2
  sof_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_data == cfg_dst_mac[47:40] && !out_eof);

  // R5
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> out_valid && out_ready && out_data == in_data && !out_sof && !out_eof);
endmodule

bind l2_tunnel_packer l2_tunnel_packer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof), .cfg_dst_mac(cfg_dst_mac), .seq(seq)
);

// File: tb/l2_tunnel_packer_tb_top.sv
module l2_tunnel_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] cfg_dst_mac = 48'h02_11_22_33_44_55;
  logic [47:0] cfg_src_mac = 48'h02_AA_BB_CC_DD_EE;
  logic [11:0] cfg_vid = 12'h5A3;
  logic [1:0]  cfg_pri = 2'd0;
  logic [3:0]  cfg_fc = 4'h9;
  logic [3:0]  cfg_ptype = 4'h6;
  logic [1:0]  cfg_ver = 2'd1;
  logic [10:0] cfg_max_pld = 11'd64;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [7:0]  in_len = 8'h00;
  logic        in_wr = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_sof;
  logic        out_eof;

  always #4 clk = ~clk;

  l2_tunnel_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dst_mac(cfg_dst_mac), .cfg_src_mac(cfg_src_mac),
    .cfg_vid(cfg_vid), .cfg_pri(cfg_pri), .cfg_fc(cfg_fc), .cfg_ptype(cfg_ptype),
    .cfg_ver(cfg_ver), .cfg_max_pld(cfg_max_pld), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .in_wr(in_wr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
  );

  // {max_pld[10:0], npkts[3:0], write_mask[7:0], write_len[7:0], pri[1:0], exp_frames[2:0]}
  localparam logic [35:0] VEC [6] = '{
    {11'd64,  4'd4, 8'h05, 8'd16, 2'd3, 3'd1},
    {11'd40,  4'd4, 8'h05, 8'd16, 2'd2, 3'd2},
    {11'd10,  4'd3, 8'h00, 8'd16, 2'd1, 3'd3},
    {11'd8,   4'd2, 8'h03, 8'd16, 2'd0, 3'd2},
    {11'd200, 4'd6, 8'h3F, 8'd12, 2'd1, 3'd1},
    {11'd28,  4'd3, 8'h02, 8'd16, 2'd2, 3'd2}
  };

  int n_chk = 0, n_fail = 0;
  int frames = 0, seq_err = 0, fpos = 0;
  logic [3:0] seq_hi = 4'h0;
  bit cap_en = 1'b1, bp_en = 1'b0;
  logic [9:0] cap_q[$];
  logic [9:0] exp_q[$];
  logic       pk_wr [16];
  int         pk_len [16];
  logic [7:0] pk_inlen [16];
  logic [7:0] pk_dat [16][32];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  initial begin
    logic [7:0] lf;
    lf = 8'h5A;
    forever begin
      @(posedge clk); #1;
      if (bp_en) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        out_ready = lf[0] | lf[2];
      end else out_ready = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (cap_en) cap_q.push_back({out_sof, out_eof, out_data});
      if (out_sof) fpos = 0;
      if (fpos == 19) seq_hi = out_data[3:0];
      if (fpos == 20 && {seq_hi, out_data} != 12'(frames % 4096)) seq_err++;
      fpos++;
      if (out_eof) frames++;
    end
  end

  task automatic push_byte(input logic [7:0] b, input logic [7:0] l, input logic w);
    in_valid = 1'b1; in_data = b; in_len = l; in_wr = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic send_all(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < pk_len[i]; j++) push_byte(pk_dat[i][j], pk_inlen[i], pk_wr[i]);
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic prep(input int v, input int n, input logic [7:0] mask, input int wl);
    for (int i = 0; i < n; i++) begin
      pk_wr[i]    = mask[i];
      pk_len[i]   = mask[i] ? wl : 8;
      pk_inlen[i] = mask[i] ? 8'(wl) : 8'hEE;
      for (int j = 0; j < 32; j++) pk_dat[i][j] = 8'(v * 37 + i * 11 + j * 3 + 5);
    end
  endtask

  task automatic push_hdr(input int seqv, input logic [1:0] pr);
    logic [7:0] hb [23];
    logic [15:0] c;
    logic [23:0] th;
    for (int k = 0; k < 6; k++) begin
      hb[k]     = cfg_dst_mac[47 - 8 * k -: 8];
      hb[6 + k] = cfg_src_mac[47 - 8 * k -: 8];
    end
    hb[12] = 8'h81; hb[13] = 8'h00;
    hb[14] = {pr, 2'b00, cfg_vid[11:8]}; hb[15] = cfg_vid[7:0];
    hb[16] = 8'h88; hb[17] = 8'hB5;
    th = {cfg_fc, pr, cfg_ptype, cfg_ver, 12'(seqv)};
    hb[18] = th[23:16]; hb[19] = th[15:8]; hb[20] = th[7:0];
    c = 16'hFFFF;
    for (int k = 18; k <= 20; k++) c = ref_crc(c, hb[k]);
    hb[21] = c[15:8]; hb[22] = c[7:0];
    for (int k = 0; k < 23; k++) exp_q.push_back({(k == 0), 1'b0, hb[k]});
  endtask

  task automatic build_exp(input int n, input int mx, input logic [1:0] pr, input bit split, output int nf);
    int used;
    logic [15:0] c;
    nf = 0; used = 0;
    for (int i = 0; i < n; i++) begin
      int tot;
      tot = pk_len[i] + 2;
      if (i == 0 || split || used + tot > mx) begin
        if (i != 0) exp_q[exp_q.size() - 1][8] = 1'b1;
        push_hdr((frames + nf) % 4096, pr);
        nf++;
        used = 0;
      end
      c = 16'hFFFF;
      for (int j = 0; j < pk_len[i]; j++) begin
        exp_q.push_back({2'b00, pk_dat[i][j]});
        c = ref_crc(c, pk_dat[i][j]);
      end
      exp_q.push_back({2'b00, c[15:8]});
      exp_q.push_back({2'b00, c[7:0]});
      used += tot;
    end
    exp_q[exp_q.size() - 1][8] = 1'b1;
  endtask

  task automatic wait_frames(input int target);
    int t;
    t = 0;
    while (frames < target && t < 20000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic cmp_stream(input string req, input string what);
    int bad, first;
    bad = 0; first = -1;
    for (int k = 0; k < exp_q.size(); k++) begin
      if (k >= cap_q.size() || cap_q[k] !== exp_q[k]) begin
        bad++;
        if (first < 0) first = k;
      end
    end
    if (bad == 0 && cap_q.size() == exp_q.size())
      chk(1'b1, req, what, 0, 0);
    else if (first < 0)
      chk(1'b0, req, {what, " length"}, cap_q.size(), exp_q.size());
    else
      chk(1'b0, req, {what, " byte"}, (first < cap_q.size()) ? cap_q[first] : 10'h3FF, exp_q[first]);
    cap_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int fr0, nf;
    logic [10:0] mx;
    logic [3:0]  n;
    logic [7:0]  mask, wl;
    logic [1:0]  pr;
    logic [2:0]  ef;
    logic [15:0] cc;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(!out_valid && !in_ready, "R1", "idle after reset", {out_valid, in_ready}, 0);

    // R4: CRC reference on the standard check string
    cc = 16'hFFFF;
    for (int k = 0; k < 9; k++) cc = ref_crc(cc, 8'h31 + 8'(k));
    chk(cc == 16'h29B1, "R4", "crc check value", cc, 16'h29B1);

    for (int v = 0; v < 6; v++) begin
      {mx, n, mask, wl, pr, ef} = VEC[v];
      cfg_max_pld = mx; cfg_pri = pr;
      prep(v, int'(n), mask, int'(wl));
      fr0 = frames;
      build_exp(int'(n), int'(mx), pr, 1'b0, nf);
      send_all(int'(n), 0);
      wait_frames(fr0 + nf);
      // R6 R7: frame count against the table
      chk(frames - fr0 == int'(ef) && nf == int'(ef), (v == 3) ? "R7" : "R6",
          $sformatf("frame count vector %0d", v), frames - fr0, ef);
      // R2 R3 R4 R5 R9 content
      cmp_stream("R2_R3_R4_R5_R9", $sformatf("stream vector %0d", v));
    end

    // R11: backpressure on the six-write vector
    bp_en = 1'b1;
    cfg_max_pld = 11'd200; cfg_pri = 2'd3;
    prep(7, 6, 8'h3F, 12);
    fr0 = frames;
    build_exp(6, 200, 2'd3, 1'b0, nf);
    send_all(6, 0);
    wait_frames(fr0 + nf);
    bp_en = 1'b0;
    cmp_stream("R11", "stream under backpressure");

    // R8: empty queue at the decision point closes the frame
    prep(8, 2, 8'h03, 12);
    fr0 = frames;
    build_exp(2, 200, 2'd3, 1'b1, nf);
    send_all(2, 30);
    wait_frames(fr0 + nf);
    chk(frames - fr0 == 2, "R8", "frames with idle gap", frames - fr0, 2);
    cmp_stream("R8", "stream with idle gap");

    // R10: sequence wrap across 4096 frames
    cap_en = 1'b0;
    cfg_max_pld = 11'd10;
    prep(9, 1, 8'h00, 8);
    fr0 = frames;
    for (int k = 0; k < 4100; k++) send_all(1, 0);
    wait_frames(fr0 + 4100);
    chk(frames - fr0 == 4100, "R10", "frames in wrap run", frames - fr0, 4100);
    chk(seq_err == 0, "R10", "sequence mismatches", seq_err, 0);

    finish_run();
  end
endmodule